// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Receiver with Error Statistics

This block receives asynchronous serial characters on a single line. It takes the line through a sampling enable that pulses sixteen times per bit period. A falling edge starts a character. Each bit is resolved by a three-sample majority vote near its centre. The receiver strips the start and stop bits and presents only the data bits, least significant bit first, as a parallel character. Two optional fields can follow the data bits: an address-tag bit that marks multidrop address characters, and a parity bit. When the address-tag bit is present, it is included in the parity check. The receiver releases the line for a new character part-way through the stop bit, so a transmitter that shortens its stop bit is still received correctly.

Each character comes out with one-cycle flags for parity error, framing error, noisy sampling and address tagging. Address characters are compared against two programmable station addresses. Ordinary data characters are compared against a table of eight control characters, each with its own enable. Five saturating counters are kept, all cleared together by a synchronous clear input. Four of them count parity errors, framing errors, noisy characters and line breaks. The fifth counts whole idle character times and raises a timeout flag once a programmable limit is reached.

Top module: `uart_mdrop_rx`

## Requirements
- R1: After reset, all five counters read zero, `char_valid` is low and `idle_timeout` is low.
- R2: A frame is one start bit (low), DATA_W data bits sent least significant bit first, an address-tag bit when `cfg_addr_en` is high, a parity bit when `cfg_par_en` is high, and one stop bit (high). `char_data` carries only the data bits, and `char_valid` pulses for exactly one clock per received character.
- R3: The first `smp_en` tick that sees the line low is sample 1 of the start bit, and each bit spans 16 ticks. A bit's value is the majority of its samples 7, 8 and 9. A start bit whose vote is high is discarded without any output. If the three samples of any voted bit in a frame disagree, `char_noise` is set and the noise counter rises by one for that frame.
- R4: The receiver hunts for a new start bit from sample 12 of the stop bit onward, so a stop bit only 11 ticks long is accepted.
- R5: With parity enabled, even mode (`cfg_par_odd`=0) expects an even number of ones across the data bits, the address-tag bit (when present) and the parity bit, and odd mode expects an odd number. A mismatch sets `char_par_err` and increments the parity counter.
- R6: A stop bit voted low in a frame that is not a break sets `char_frm_err` and increments the framing counter.
- R7: A frame whose voted bits are all low, stop bit included, is a break. It produces no `char_valid`, raises the break counter once and sets no parity or framing flag. The receiver then waits for the line to be sampled high before it hunts again, so a long low line counts as one break.
- R8: Every counter stops at its all-ones value. A high `cnt_clr` clears all five counters to zero on the next clock edge.
- R9: While the receiver is hunting and the line is sampled high, each run of (2 + DATA_W + addr + parity) × 16 ticks increments the idle counter. A confirmed start bit clears the idle counter. `idle_timeout` is high when `cfg_max_idle` is nonzero and the idle counter is at or above it.
- R10: With `cfg_addr_en` high and the address-tag bit received as 1, `char_is_addr` is set, and `char_addr_hit` is set when `char_data` equals `cfg_addr1` or `cfg_addr2`.
- R11: A character without the address tag is compared with control entry k, held at `cfg_ctrl_chars[k*DATA_W +: DATA_W]` and enabled by `cfg_ctrl_en[k]`. `char_ctrl_hit` reports a match, and `char_ctrl_idx` gives the lowest matching enabled index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Oversampling tick, 16 per bit period |
| rxd | input | 1 | Serial receive line |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_addr_en | input | 1 | Address-tag bit present after the data bits |
| cfg_max_idle | input | CNT_W | Idle character limit; 0 disables the timeout |
| cfg_addr1 | input | DATA_W | First station address |
| cfg_addr2 | input | DATA_W | Second station address |
| cfg_ctrl_chars | input | NUM_CTRL*DATA_W | Control character table |
| cfg_ctrl_en | input | NUM_CTRL | Per-entry enables for the control table |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| char_valid | output | 1 | One-cycle strobe for a received character |
| char_data | output | DATA_W | Received data bits |
| char_par_err | output | 1 | Parity check failed |
| char_frm_err | output | 1 | Stop bit was low |
| char_noise | output | 1 | Sample disagreement within the frame |
| char_is_addr | output | 1 | Address-tag bit was 1 |
| char_addr_hit | output | 1 | Address character matched a station address |
| char_ctrl_hit | output | 1 | Data character matched an enabled control entry |
| char_ctrl_idx | output | $clog2(NUM_CTRL) | Lowest matching control entry |
| idle_timeout | output | 1 | Idle counter reached the limit |
| cnt_parity | output | CNT_W | Parity error count |
| cnt_framing | output | CNT_W | Framing error count |
| cnt_noise | output | CNT_W | Noisy character count |
| cnt_break | output | CNT_W | Break count |
| cnt_idle | output | CNT_W | Idle character count |

## Verification
The assertions assume that the configuration inputs stay steady while a frame is in flight, and that `smp_en` never pulses on two back-to-back clocks. The counter properties also assume that `cnt_clr` is the only way to reduce a counter. The stimulus meets these assumptions by changing configuration only between frames with the line idle, and by driving every sample as a one-clock enable followed by a quiet clock. Noise is injected only as a single flipped vote sample, so the majority vote still recovers the intended bit. The 3-bit counter instance lets saturation be reached within the run.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    // Oversampling ratio and sample positions (0-based tick index within a bit)
    localparam int OVS         = 16;
    localparam int VOTE_A      = 6;   // sample 7
    localparam int VOTE_B      = 7;   // sample 8
    localparam int VOTE_C      = 8;   // sample 9, decision point
    localparam int STOP_FREE   = 10;  // sample 11: hunting resumes afterwards
    localparam int NUM_EVT_CNT = 5;

    // Counter slots in the statistics block
    localparam int CNT_PAR  = 0;
    localparam int CNT_FRM  = 1;
    localparam int CNT_NSE  = 2;
    localparam int CNT_BRK  = 3;
    localparam int CNT_IDLE = 4;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_ADDR,
        RX_PAR,
        RX_STOP,
        RX_BRKW
    } rx_state_e;

    typedef struct packed {
        logic addr_bit;
        logic par_err;
        logic frm_err;
        logic noise;
        logic brk;
    } rx_flags_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return !((a == b) && (b == c));
    endfunction

endpackage

// File: rtl/uart_rx_satcnt.sv
module uart_rx_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (inc && (q != '1)) begin
            q <= q + 1'b1;
        end
    end

    p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (q == '1 && !clr) |=> (q == '1));

    p_no_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr) |=> (q >= $past(q)));

    p_clr_zero_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_en,
    input  logic              rxd,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_addr_en,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output rx_flags_t         flags,
    output logic              start_ok,
    output logic              hunting
);

    localparam int BIT_W = $clog2(DATA_W + 1);

    rx_state_e         st;
    logic [3:0]        sidx;
    logic [BIT_W-1:0]  bidx;
    logic              s7, s8;
    logic [DATA_W-1:0] shreg;
    logic              addr_q;
    logic              par_acc;
    logic              noise_acc;
    logic              zero_acc;

    logic      vote, split, brk_now, at_vote, at_end;
    rx_state_e after_data, after_addr;

    always_comb begin
        vote       = maj3(s7, s8, rxd);
        split      = split3(s7, s8, rxd);
        brk_now    = zero_acc && !vote;
        at_vote    = (sidx == 4'(VOTE_C));
        at_end     = (sidx == 4'(OVS - 1));
        after_addr = cfg_par_en ? RX_PAR : RX_STOP;
        after_data = cfg_addr_en ? RX_ADDR : after_addr;
        hunting    = (st == RX_HUNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_HUNT;
            sidx      <= '0;
            bidx      <= '0;
            s7        <= 1'b1;
            s8        <= 1'b1;
            shreg     <= '0;
            addr_q    <= 1'b0;
            par_acc   <= 1'b0;
            noise_acc <= 1'b0;
            zero_acc  <= 1'b1;
            done      <= 1'b0;
            data      <= '0;
            flags     <= '0;
            start_ok  <= 1'b0;
        end else begin
            done     <= 1'b0;
            start_ok <= 1'b0;
            if (smp_en) begin
                case (st)
                    RX_HUNT: begin
                        if (!rxd) begin
                            st   <= RX_START;
                            sidx <= 4'd1;
                        end
                    end
                    RX_BRKW: begin
                        if (rxd) st <= RX_HUNT;
                    end
                    default: begin
                        sidx <= sidx + 4'd1;
                        if (sidx == 4'(VOTE_A)) s7 <= rxd;
                        if (sidx == 4'(VOTE_B)) s8 <= rxd;
                        case (st)
                            RX_START: begin
                                if (at_vote) begin
                                    if (vote) begin
                                        st <= RX_HUNT;
                                    end else begin
                                        start_ok  <= 1'b1;
                                        noise_acc <= split;
                                        par_acc   <= 1'b0;
                                        zero_acc  <= 1'b1;
                                        addr_q    <= 1'b0;
                                        bidx      <= '0;
                                    end
                                end else if (at_end) begin
                                    st <= RX_DATA;
                                end
                            end
                            RX_DATA: begin
                                if (at_vote) begin
                                    shreg     <= {vote, shreg[DATA_W-1:1]};
                                    par_acc   <= par_acc ^ vote;
                                    noise_acc <= noise_acc | split;
                                    zero_acc  <= zero_acc & !vote;
                                end else if (at_end) begin
                                    if (bidx == BIT_W'(DATA_W - 1)) begin
                                        st <= after_data;
                                    end else begin
                                        bidx <= bidx + 1'b1;
                                    end
                                end
                            end
                            RX_ADDR: begin
                                if (at_vote) begin
                                    addr_q    <= vote;
                                    par_acc   <= par_acc ^ vote;
                                    noise_acc <= noise_acc | split;
                                    zero_acc  <= zero_acc & !vote;
                                end else if (at_end) begin
                                    st <= after_addr;
                                end
                            end
                            RX_PAR: begin
                                if (at_vote) begin
                                    par_acc   <= par_acc ^ vote;
                                    noise_acc <= noise_acc | split;
                                    zero_acc  <= zero_acc & !vote;
                                end else if (at_end) begin
                                    st <= RX_STOP;
                                end
                            end
                            RX_STOP: begin
                                if (at_vote) begin
                                    done           <= 1'b1;
                                    data           <= shreg;
                                    flags.addr_bit <= addr_q;
                                    flags.par_err  <= cfg_par_en && (par_acc ^ cfg_par_odd) && !brk_now;
                                    flags.frm_err  <= !vote && !brk_now;
                                    flags.noise    <= noise_acc | split;
                                    flags.brk      <= brk_now;
                                    if (brk_now) st <= RX_BRKW;
                                end else if (sidx == 4'(STOP_FREE)) begin
                                    st <= RX_HUNT;
                                end
                            end
                            default: st <= RX_HUNT;
                        endcase
                    end
                endcase
            end
        end
    end

    p_done_from_stop_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(st) == RX_STOP));

    p_start_from_start_r3: assert property (@(posedge clk) disable iff (rst)
        start_ok |-> ($past(st) == RX_START));

    p_brk_holds_low_r7: assert property (@(posedge clk) disable iff (rst)
        (st == RX_BRKW && !(smp_en && rxd)) |=> (st == RX_BRKW));

    p_stop_release_r4: assert property (@(posedge clk) disable iff (rst)
        (st == RX_STOP && smp_en && sidx == 4'(STOP_FREE)) |=> hunting);

    p_brk_no_err_r7: assert property (@(posedge clk) disable iff (rst)
        (done && flags.brk) |-> !(flags.par_err || flags.frm_err));

endmodule

// File: rtl/uart_rx_stats.sv
module uart_rx_stats
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_en,
    input  logic             rxd,
    input  logic             clr,
    input  logic             done,
    input  logic             ev_par,
    input  logic             ev_frm,
    input  logic             ev_nse,
    input  logic             ev_brk,
    input  logic             start_ok,
    input  logic             hunting,
    input  logic             cfg_par_en,
    input  logic             cfg_addr_en,
    input  logic [CNT_W-1:0] cfg_max_idle,
    output logic [CNT_W-1:0] cnt_par,
    output logic [CNT_W-1:0] cnt_frm,
    output logic [CNT_W-1:0] cnt_nse,
    output logic [CNT_W-1:0] cnt_brk,
    output logic [CNT_W-1:0] cnt_idle,
    output logic             idle_timeout
);

    localparam int TICK_W = $clog2((DATA_W + 4) * OVS + 1);

    logic [TICK_W-1:0] tick_cnt;
    logic [TICK_W-1:0] frame_ticks;
    logic              idle_smp;
    logic              idle_char;

    logic [NUM_EVT_CNT-1:0] ev_inc;
    logic [NUM_EVT_CNT-1:0] ev_clr;
    logic [CNT_W-1:0]       cnt_q [NUM_EVT_CNT];

    always_comb begin
        frame_ticks = TICK_W'((2 + DATA_W) * OVS)
                    + (cfg_addr_en ? TICK_W'(OVS) : '0)
                    + (cfg_par_en  ? TICK_W'(OVS) : '0);
        idle_smp  = smp_en && hunting && rxd;
        idle_char = idle_smp && (tick_cnt == frame_ticks - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tick_cnt <= '0;
        end else if (smp_en) begin
            if (!(hunting && rxd) || idle_char) begin
                tick_cnt <= '0;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        ev_inc            = '0;
        ev_clr            = {NUM_EVT_CNT{clr}};
        ev_inc[CNT_PAR]   = done && ev_par;
        ev_inc[CNT_FRM]   = done && ev_frm;
        ev_inc[CNT_NSE]   = done && ev_nse;
        ev_inc[CNT_BRK]   = done && ev_brk;
        ev_inc[CNT_IDLE]  = idle_char;
        ev_clr[CNT_IDLE]  = clr || start_ok;
    end

    for (genvar g = 0; g < NUM_EVT_CNT; g++) begin : g_cnt
        uart_rx_satcnt #(.W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (ev_clr[g]),
            .inc (ev_inc[g]),
            .q   (cnt_q[g])
        );
    end

    assign cnt_par      = cnt_q[CNT_PAR];
    assign cnt_frm      = cnt_q[CNT_FRM];
    assign cnt_nse      = cnt_q[CNT_NSE];
    assign cnt_brk      = cnt_q[CNT_BRK];
    assign cnt_idle     = cnt_q[CNT_IDLE];
    assign idle_timeout = (cfg_max_idle != '0) && (cnt_idle >= cfg_max_idle);

    p_idle_only_hunting_r9: assert property (@(posedge clk) disable iff (rst)
        (!hunting && !clr && !start_ok) |=> $stable(cnt_idle));

    p_brk_only_on_frame_r7: assert property (@(posedge clk) disable iff (rst)
        (!(done && ev_brk) && !clr) |=> $stable(cnt_brk));

    p_par_only_on_frame_r5: assert property (@(posedge clk) disable iff (rst)
        (!(done && ev_par) && !clr) |=> $stable(cnt_par));

endmodule

// File: rtl/uart_rx_match.sv
module uart_rx_match #(
    parameter int DATA_W   = 8,
    parameter int NUM_CTRL = 8,
    parameter int IDX_W    = $clog2(NUM_CTRL)
) (
    input  logic [DATA_W-1:0]          data,
    input  logic                       is_addr,
    input  logic [DATA_W-1:0]          cfg_addr1,
    input  logic [DATA_W-1:0]          cfg_addr2,
    input  logic [NUM_CTRL*DATA_W-1:0] cfg_ctrl_chars,
    input  logic [NUM_CTRL-1:0]        cfg_ctrl_en,
    output logic                       addr_hit,
    output logic                       ctrl_hit,
    output logic [IDX_W-1:0]           ctrl_idx
);

    logic [NUM_CTRL-1:0] eq;
    logic                any;

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_cmp
        assign eq[g] = cfg_ctrl_en[g] && (data == cfg_ctrl_chars[g*DATA_W +: DATA_W]);
    end

    always_comb begin
        any      = 1'b0;
        ctrl_idx = '0;
        for (int k = NUM_CTRL - 1; k >= 0; k--) begin
            if (eq[k]) begin
                any      = 1'b1;
                ctrl_idx = IDX_W'(k);
            end
        end
        ctrl_hit = any && !is_addr;
        addr_hit = is_addr && ((data == cfg_addr1) || (data == cfg_addr2));
    end

endmodule

// File: rtl/uart_mdrop_rx.sv
module uart_mdrop_rx
    import uart_rx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 16,
    parameter int NUM_CTRL = 8,
    parameter int IDX_W    = $clog2(NUM_CTRL)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_en,
    input  logic                       rxd,
    input  logic                       cfg_par_en,
    input  logic                       cfg_par_odd,
    input  logic                       cfg_addr_en,
    input  logic [CNT_W-1:0]           cfg_max_idle,
    input  logic [DATA_W-1:0]          cfg_addr1,
    input  logic [DATA_W-1:0]          cfg_addr2,
    input  logic [NUM_CTRL*DATA_W-1:0] cfg_ctrl_chars,
    input  logic [NUM_CTRL-1:0]        cfg_ctrl_en,
    input  logic                       cnt_clr,
    output logic                       char_valid,
    output logic [DATA_W-1:0]          char_data,
    output logic                       char_par_err,
    output logic                       char_frm_err,
    output logic                       char_noise,
    output logic                       char_is_addr,
    output logic                       char_addr_hit,
    output logic                       char_ctrl_hit,
    output logic [IDX_W-1:0]           char_ctrl_idx,
    output logic                       idle_timeout,
    output logic [CNT_W-1:0]           cnt_parity,
    output logic [CNT_W-1:0]           cnt_framing,
    output logic [CNT_W-1:0]           cnt_noise,
    output logic [CNT_W-1:0]           cnt_break,
    output logic [CNT_W-1:0]           cnt_idle
);

    logic              f_done;
    logic [DATA_W-1:0] f_data;
    rx_flags_t         f_flags;
    logic              f_start_ok;
    logic              f_hunting;

    uart_rx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .smp_en      (smp_en),
        .rxd         (rxd),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_addr_en (cfg_addr_en),
        .done        (f_done),
        .data        (f_data),
        .flags       (f_flags),
        .start_ok    (f_start_ok),
        .hunting     (f_hunting)
    );

    uart_rx_stats #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_stats (
        .clk          (clk),
        .rst          (rst),
        .smp_en       (smp_en),
        .rxd          (rxd),
        .clr          (cnt_clr),
        .done         (f_done),
        .ev_par       (f_flags.par_err),
        .ev_frm       (f_flags.frm_err),
        .ev_nse       (f_flags.noise),
        .ev_brk       (f_flags.brk),
        .start_ok     (f_start_ok),
        .hunting      (f_hunting),
        .cfg_par_en   (cfg_par_en),
        .cfg_addr_en  (cfg_addr_en),
        .cfg_max_idle (cfg_max_idle),
        .cnt_par      (cnt_parity),
        .cnt_frm      (cnt_framing),
        .cnt_nse      (cnt_noise),
        .cnt_brk      (cnt_break),
        .cnt_idle     (cnt_idle),
        .idle_timeout (idle_timeout)
    );

    uart_rx_match #(.DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL), .IDX_W(IDX_W)) u_match (
        .data           (f_data),
        .is_addr        (f_flags.addr_bit),
        .cfg_addr1      (cfg_addr1),
        .cfg_addr2      (cfg_addr2),
        .cfg_ctrl_chars (cfg_ctrl_chars),
        .cfg_ctrl_en    (cfg_ctrl_en),
        .addr_hit       (char_addr_hit),
        .ctrl_hit       (char_ctrl_hit),
        .ctrl_idx       (char_ctrl_idx)
    );

    assign char_valid   = f_done && !f_flags.brk;
    assign char_data    = f_data;
    assign char_par_err = f_flags.par_err;
    assign char_frm_err = f_flags.frm_err;
    assign char_noise   = f_flags.noise;
    assign char_is_addr = f_flags.addr_bit;

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        char_valid |=> !char_valid);

    p_addr_not_ctrl_r11: assert property (@(posedge clk) disable iff (rst)
        (char_valid && char_is_addr) |-> !char_ctrl_hit);

    p_tag_needs_mode_r10: assert property (@(posedge clk) disable iff (rst)
        (char_valid && !cfg_addr_en) |-> !char_is_addr);

endmodule

// File: tb/uart_mdrop_rx_tb_top.sv
`timescale 1ns/1ps
module uart_mdrop_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_en = 1'b0;
    logic        rxd = 1'b1;
    logic        par_en = 1'b0, par_odd = 1'b0, addr_en = 1'b0;
    logic [15:0] max_idle = '0;
    logic [7:0]  a1 = 8'h5A, a2 = 8'hC3;
    logic [63:0] ctrl_flat;
    logic [7:0]  ctrl_en = 8'b1111_0111;
    logic        cnt_clr = 1'b0;
    logic [7:0]  ctab [8];

    logic        char_valid, char_par_err, char_frm_err, char_noise;
    logic        char_is_addr, char_addr_hit, char_ctrl_hit, idle_timeout;
    logic [7:0]  char_data;
    logic [2:0]  char_ctrl_idx;
    logic [15:0] cnt_parity, cnt_framing, cnt_noise, cnt_break, cnt_idle;

    logic        s_valid, s_par, s_frm, s_nse, s_isa, s_ah, s_ch, s_to;
    logic [7:0]  s_data;
    logic [2:0]  s_idx, s_cp, s_cf, s_cn, s_cb, s_ci;

    always #10 clk = ~clk;

    always_comb for (int k = 0; k < 8; k++) ctrl_flat[k*8 +: 8] = ctab[k];

    uart_mdrop_rx dut_i (
        .clk(clk), .rst(rst), .smp_en(smp_en), .rxd(rxd),
        .cfg_par_en(par_en), .cfg_par_odd(par_odd), .cfg_addr_en(addr_en),
        .cfg_max_idle(max_idle), .cfg_addr1(a1), .cfg_addr2(a2),
        .cfg_ctrl_chars(ctrl_flat), .cfg_ctrl_en(ctrl_en), .cnt_clr(cnt_clr),
        .char_valid(char_valid), .char_data(char_data), .char_par_err(char_par_err),
        .char_frm_err(char_frm_err), .char_noise(char_noise), .char_is_addr(char_is_addr),
        .char_addr_hit(char_addr_hit), .char_ctrl_hit(char_ctrl_hit),
        .char_ctrl_idx(char_ctrl_idx), .idle_timeout(idle_timeout),
        .cnt_parity(cnt_parity), .cnt_framing(cnt_framing), .cnt_noise(cnt_noise),
        .cnt_break(cnt_break), .cnt_idle(cnt_idle)
    );

    // Narrow-counter copy so saturation is reachable (R8)
    uart_mdrop_rx #(.CNT_W(3)) dut_sat_i (
        .clk(clk), .rst(rst), .smp_en(smp_en), .rxd(rxd),
        .cfg_par_en(par_en), .cfg_par_odd(par_odd), .cfg_addr_en(addr_en),
        .cfg_max_idle(max_idle[2:0]), .cfg_addr1(a1), .cfg_addr2(a2),
        .cfg_ctrl_chars(ctrl_flat), .cfg_ctrl_en(ctrl_en), .cnt_clr(cnt_clr),
        .char_valid(s_valid), .char_data(s_data), .char_par_err(s_par),
        .char_frm_err(s_frm), .char_noise(s_nse), .char_is_addr(s_isa),
        .char_addr_hit(s_ah), .char_ctrl_hit(s_ch), .char_ctrl_idx(s_idx),
        .idle_timeout(s_to), .cnt_parity(s_cp), .cnt_framing(s_cf),
        .cnt_noise(s_cn), .cnt_break(s_cb), .cnt_idle(s_ci)
    );

    int total = 0, bad = 0;
    int got_n = 0;
    logic [7:0] g_data;
    logic g_par, g_frm, g_nse, g_isa, g_ah, g_ch;
    logic [2:0] g_idx;
    int e_par = 0, e_frm = 0, e_nse = 0, e_brk = 0;

    always @(negedge clk) begin
        if (char_valid) begin
            got_n++;
            g_data = char_data; g_par = char_par_err; g_frm = char_frm_err;
            g_nse = char_noise; g_isa = char_is_addr; g_ah = char_addr_hit;
            g_ch = char_ctrl_hit; g_idx = char_ctrl_idx;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic v);
        @(negedge clk); rxd = v; smp_en = 1'b1;
        @(negedge clk); smp_en = 1'b0;
    endtask

    task automatic ticks(input logic v, input int n);
        for (int i = 0; i < n; i++) tick(v);
    endtask

    task automatic send_bit(input logic v, input bit disturb);
        for (int s = 0; s < 16; s++) tick((disturb && s == 6) ? ~v : v);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic ab, input bit flip_par,
                              input bit frm, input int stop_ticks, input int nz_bit);
        logic p;
        p = ^d ^ (addr_en & ab);
        if (par_odd) p = ~p;
        if (flip_par) p = ~p;
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i], nz_bit == i);
        if (addr_en) send_bit(ab, 1'b0);
        if (par_en) send_bit(p, 1'b0);
        if (frm) begin ticks(1'b0, 11); ticks(1'b1, 5); end
        else ticks(1'b1, stop_ticks);
    endtask

    // Send one character and compare every per-character output
    task automatic do_char(input logic [7:0] d, input logic ab, input bit flip_par,
                           input bit frm, input int stop_ticks, input int nz_bit);
        int n0; logic ia, ah, ch; logic [2:0] ix;
        n0 = got_n;
        send_frame(d, ab, flip_par, frm, stop_ticks, nz_bit);
        ia = addr_en && ab;
        ah = ia && (d == a1 || d == a2);
        ch = 1'b0; ix = '0;
        for (int k = 7; k >= 0; k--)
            if (ctrl_en[k] && ctab[k] == d) begin ch = 1'b1; ix = 3'(k); end
        ch = ch && !ia;
        chk("R2 one strobe per char", got_n, n0 + 1);
        chk("R2 data bits", g_data, d);
        chk("R5 parity flag", g_par, par_en && flip_par);
        chk("R6 framing flag", g_frm, frm);
        chk("R3 noise flag", g_nse, nz_bit >= 0);
        chk("R10 address tag", g_isa, ia);
        chk("R10 address hit", g_ah, ah);
        chk("R11 control hit", g_ch, ch);
        if (ch) chk("R11 control index", g_idx, ix);
        e_par += (par_en && flip_par) ? 1 : 0;
        e_frm += frm ? 1 : 0;
        e_nse += (nz_bit >= 0) ? 1 : 0;
    endtask

    function automatic int sat7(input int v);
        return (v > 7) ? 7 : v;
    endfunction

    task automatic chk_counters(input string ph);
        chk({"R5 parity count ", ph}, cnt_parity, e_par);
        chk({"R6 framing count ", ph}, cnt_framing, e_frm);
        chk({"R3 noise count ", ph}, cnt_noise, e_nse);
        chk({"R7 break count ", ph}, cnt_break, e_brk);
        chk({"R8 narrow parity sat ", ph}, s_cp, sat7(e_par));
        chk({"R8 narrow noise sat ", ph}, s_cn, sat7(e_nse));
        chk({"R8 narrow framing sat ", ph}, s_cf, sat7(e_frm));
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d; logic ab; bit fp, fr; int st, nz;
            d  = 8'($urandom);
            if ($urandom % 2 == 0) d = ctab[$urandom % 8];
            ab = addr_en ? 1'($urandom % 2) : 1'b0;
            if (addr_en && $urandom % 4 == 0) begin d = ($urandom % 2) ? a1 : a2; ab = 1'b1; end
            fp = par_en && ($urandom % 6 == 0);
            fr = ($urandom % 7 == 0);
            if (fr && d == 8'h00) d = 8'h01;
            nz = ($urandom % 5 == 0) ? int'($urandom % 8) : -1;
            st = 11 + int'($urandom % 6);
            do_char(d, ab, fp, fr, st, nz);
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
        e_par = 0; e_frm = 0; e_nse = 0; e_brk = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n0;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) ctab[k] = 8'h20 + 8'(k * 17);
        ctab[5] = ctab[2];
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 parity count reset", cnt_parity, 0);
        chk("R1 framing count reset", cnt_framing, 0);
        chk("R1 noise count reset", cnt_noise, 0);
        chk("R1 break count reset", cnt_break, 0);
        chk("R1 idle count reset", cnt_idle, 0);
        chk("R1 strobe low", char_valid, 0);
        chk("R1 timeout low", idle_timeout, 0);

        // Config A: even parity, address tag present
        par_en = 1'b1; par_odd = 1'b0; addr_en = 1'b1; max_idle = 16'd3;
        ticks(1'b1, 20);
        do_char(8'h5A, 1'b1, 0, 0, 16, -1);        // R10 station 1
        do_char(8'hC3, 1'b1, 0, 0, 16, -1);        // R10 station 2
        do_char(8'h11, 1'b1, 0, 0, 16, -1);        // R10 no match
        do_char(ctab[2], 1'b0, 0, 0, 16, -1);      // R11 duplicate, lowest index wins
        do_char(ctab[3], 1'b0, 0, 0, 16, -1);      // R11 disabled entry
        do_char(ctab[2], 1'b1, 0, 0, 16, -1);      // R11 tagged char never a control hit
        do_char(8'hB7, 1'b0, 1, 0, 16, -1);        // R5 parity error
        do_char(8'h80, 1'b1, 1, 0, 16, -1);        // R5 tag bit counted in parity
        do_char(8'h3C, 1'b0, 0, 1, 16, -1);        // R6 framing error
        do_char(8'hA5, 1'b0, 0, 0, 16, 3);         // R3 noise
        do_char(8'h96, 1'b0, 0, 0, 11, -1);        // R4 short stop
        do_char(8'h69, 1'b0, 0, 0, 11, -1);        // R4 back-to-back
        do_char(8'h00, 1'b0, 0, 0, 16, -1);        // zero data with high stop is a character

        // R3 false start
        n0 = got_n;
        ticks(1'b0, 5); ticks(1'b1, 40);
        chk("R3 false start ignored", got_n, n0);

        // R7 long break counted once
        n0 = got_n;
        ticks(1'b0, 12 * 16 + 60); ticks(1'b1, 20);
        e_brk++;
        chk("R7 break gives no strobe", got_n, n0);
        chk("R7 break counted once", cnt_break, e_brk);
        chk_counters("directed");

        // R9 idle characters: 5 trailing stop ticks plus these
        do_char(8'h42, 1'b0, 0, 0, 16, -1);
        ticks(1'b1, 3 * 192 - 5 - 1);
        chk("R9 idle count before limit", cnt_idle, 2);
        chk("R9 timeout below limit", idle_timeout, 0);
        tick(1'b1);
        chk("R9 idle count at limit", cnt_idle, 3);
        chk("R9 timeout at limit", idle_timeout, 1);
        do_char(8'h24, 1'b0, 0, 0, 16, -1);
        chk("R9 start clears idle", cnt_idle, 0);
        chk("R9 timeout cleared", idle_timeout, 0);

        random_run(80);
        chk_counters("phase A");

        pulse_clear();
        chk("R8 clear parity", cnt_parity, 0);
        chk("R8 clear framing", cnt_framing, 0);
        chk("R8 clear noise", cnt_noise, 0);
        chk("R8 clear break", cnt_break, 0);
        chk("R8 clear narrow noise", s_cn, 0);

        // Config B: odd parity, no address tag
        par_odd = 1'b1; addr_en = 1'b0; max_idle = 16'd0;
        ticks(1'b1, 20);
        do_char(8'h5A, 1'b1, 0, 0, 16, -1);        // R10 tag absent
        do_char(8'hF0, 1'b0, 1, 0, 13, 7);         // R5 odd parity error with noise
        random_run(60);
        chk_counters("phase B");
        chk("R9 no timeout with zero limit", idle_timeout, 0);

        finish_run();
    end

endmodule